// File: doc/BRIEF.md
# Buffered Periodic Error Tally

The block tallies one chosen class of transmission error into a 16-bit running count. The count is never read directly. A transfer copies it into a held register, which is presented as a high byte and a low byte, and the same transfer restarts the running count. Transfers happen in one of two ways. In automatic mode, a free-running timer on the master clock causes a transfer once per second. In manual mode, the host requests a transfer with a one-cycle strobe.

The block raises two flags:
- a timer flag, set each time the one-second timer expires;
- an overflow flag, set when the running count would go past all ones.

The host clears each flag by writing a one to its clear input. If a flag is not masked, it drives the combined interrupt line.

Inside, the accumulator is a two-state machine:
- `ACC_COUNT`: the count is below all ones. `COUNT->FULL` happens when the count reaches 16'hFFFF, and `COUNT->COUNT` happens on any other update.
- `ACC_FULL`: the count is saturated. `FULL->COUNT` happens on a transfer, and `FULL->FULL` happens otherwise.

The choice of error source goes through a separate selector, and the timer is a separate counter.

Top module: `err_tally_top`

## Requirements
- R1: While `rst_n` is low, and right after it is released, the held bytes, both flags and `irq` are 0. The running count is also 0.
- R2: `src_sel` picks the source that feeds the count, with this encoding:
  - 0: line BPV
  - 1: line EXZ
  - 2: line BPV plus EXZ
  - 3: system BPV
  - 4: system EXZ
  - 5: system BPV plus EXZ
  - 6: pattern error
  - 7: nothing counted

  Each cycle in which the selected strobe is high adds 1.
- R3: For codes 2 and 5, a cycle in which both strobes are high adds 2.
- R4: While `tx_nrz` is 1, codes 3 and 5 add nothing. Code 4 still counts.
- R5: The timer expires once every `SEC_CYCLES` cycles. The first expiry is at the `SEC_CYCLES`-th clock edge after reset is released. In automatic mode (`auto_mode`=1), an expiry copies the running count into `held_hi`/`held_lo` and restarts the count. Errors that arrive in the expiry cycle start the new count.
- R6: In manual mode, `upd_req` performs the same copy-and-restart, and timer expiries do not transfer. In automatic mode, `upd_req` is ignored.
- R7: Every timer expiry sets `tmr_flag`, whatever the mode. `tmr_clr`=1 clears the flag, but an expiry in the same cycle takes priority.
- R8: If an update would take the running count past 16'hFFFF, the count saturates at 16'hFFFF and `ovf_flag` is set. `ovf_clr`=1 clears the flag, and a new overflow in the same cycle takes priority.
- R9: `irq` is 1 exactly when a flag is set and its mask bit (`tmr_mask`, `ovf_mask`) is 0.
- R10: Between transfers the held bytes keep their value. The next transfer overwrites them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_line_bpv | input | 1 | Line-side bipolar violation strobe |
| ev_line_exz | input | 1 | Line-side excess-zeros strobe |
| ev_sys_bpv | input | 1 | System-side bipolar violation strobe |
| ev_sys_exz | input | 1 | System-side excess-zeros strobe |
| ev_pattern | input | 1 | Test-pattern bit error strobe |
| src_sel | input | 3 | Source select code |
| auto_mode | input | 1 | 1: timer-driven transfer, 0: host-driven transfer |
| upd_req | input | 1 | Manual transfer strobe |
| tx_nrz | input | 1 | Transmit path is in single-rail NRZ format |
| tmr_mask | input | 1 | Masks the timer flag from `irq` |
| ovf_mask | input | 1 | Masks the overflow flag from `irq` |
| tmr_clr | input | 1 | Write-one-to-clear for the timer flag |
| ovf_clr | input | 1 | Write-one-to-clear for the overflow flag |
| held_hi | output | 8 | High byte of the held count |
| held_lo | output | 8 | Low byte of the held count |
| tmr_flag | output | 1 | Timer expiry flag |
| ovf_flag | output | 1 | Counter overflow flag |
| irq | output | 1 | Combined interrupt |

## Verification
A running count that goes wrong cannot be seen at once. It appears at the first transfer that follows, as a wrong value in `held_hi`/`held_lo`. The bench therefore forces frequent transfers, either with manual strobes or with a short timer period, so that a fault surfaces within a few dozen cycles. A wrong state in the timer or the flags shows up in the very next cycle on `tmr_flag`, `ovf_flag` or `irq`. A saturation fault only shows after about 33,000 double-weight errors, so one long run drives the count into the `ACC_FULL` state.

// File: rtl/err_tally_pkg.sv
package err_tally_pkg;

    typedef enum logic [2:0] {
        SRC_LINE_BPV  = 3'd0,
        SRC_LINE_EXZ  = 3'd1,
        SRC_LINE_BOTH = 3'd2,
        SRC_SYS_BPV   = 3'd3,
        SRC_SYS_EXZ   = 3'd4,
        SRC_SYS_BOTH  = 3'd5,
        SRC_PATTERN   = 3'd6,
        SRC_NONE      = 3'd7
    } src_sel_e;

    typedef enum logic {
        ACC_COUNT = 1'b0,
        ACC_FULL  = 1'b1
    } acc_state_e;

endpackage

// File: rtl/err_src_mux.sv
module err_src_mux
    import err_tally_pkg::*;
(
    input  logic       ev_line_bpv,
    input  logic       ev_line_exz,
    input  logic       ev_sys_bpv,
    input  logic       ev_sys_exz,
    input  logic       ev_pattern,
    input  logic [2:0] src_sel,
    input  logic       tx_nrz,
    output logic [1:0] inc
);

    src_sel_e sel_e;
    assign sel_e = src_sel_e'(src_sel);

    always_comb begin
        inc = 2'd0;
        unique case (sel_e)
            SRC_LINE_BPV:  inc = {1'b0, ev_line_bpv};
            SRC_LINE_EXZ:  inc = {1'b0, ev_line_exz};
            SRC_LINE_BOTH: inc = {1'b0, ev_line_bpv} + {1'b0, ev_line_exz};
            SRC_SYS_BPV:   inc = tx_nrz ? 2'd0 : {1'b0, ev_sys_bpv};
            SRC_SYS_EXZ:   inc = {1'b0, ev_sys_exz};
            SRC_SYS_BOTH:  inc = tx_nrz ? 2'd0
                                        : ({1'b0, ev_sys_bpv} + {1'b0, ev_sys_exz});
            SRC_PATTERN:   inc = {1'b0, ev_pattern};
            SRC_NONE:      inc = 2'd0;
        endcase
    end

endmodule

// File: rtl/err_sec_timer.sv
module err_sec_timer #(
    parameter int SEC_CYCLES = 100_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    localparam int TW = (SEC_CYCLES > 2) ? $clog2(SEC_CYCLES) : 1;
    localparam logic [TW-1:0] LAST = TW'(SEC_CYCLES - 1);

    logic [TW-1:0] tmr_cnt;

    assign tick = (tmr_cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_cnt <= '0;
        end else if (tick) begin
            tmr_cnt <= '0;
        end else begin
            tmr_cnt <= tmr_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/err_accum.sv
module err_accum
    import err_tally_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       inc,
    input  logic             xfer,
    output logic [CNT_W-1:0] run_cnt,
    output logic [CNT_W-1:0] held,
    output logic             ovf_evt,
    output acc_state_e       state
);

    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    acc_state_e       state_nx;
    logic [CNT_W-1:0] cnt_nx;
    logic [CNT_W-1:0] held_nx;
    logic [CNT_W:0]   sum;

    assign sum = {1'b0, run_cnt} + {{(CNT_W - 1){1'b0}}, inc};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ACC_COUNT;
            run_cnt <= '0;
            held    <= '0;
        end else begin
            state   <= state_nx;
            run_cnt <= cnt_nx;
            held    <= held_nx;
        end
    end

    always_comb begin
        state_nx = state;
        cnt_nx   = run_cnt;
        held_nx  = held;
        ovf_evt  = 1'b0;
        unique case (state)
            ACC_COUNT: begin
                if (xfer) begin
                    held_nx  = run_cnt;
                    cnt_nx   = {{(CNT_W - 2){1'b0}}, inc};
                    state_nx = ACC_COUNT;
                end else if (sum[CNT_W]) begin
                    cnt_nx   = ALL_ONES;
                    ovf_evt  = 1'b1;
                    state_nx = ACC_FULL;
                end else begin
                    cnt_nx   = sum[CNT_W-1:0];
                    state_nx = (sum[CNT_W-1:0] == ALL_ONES) ? ACC_FULL : ACC_COUNT;
                end
            end
            ACC_FULL: begin
                if (xfer) begin
                    held_nx  = run_cnt;
                    cnt_nx   = {{(CNT_W - 2){1'b0}}, inc};
                    state_nx = ACC_COUNT;
                end else begin
                    cnt_nx   = ALL_ONES;
                    ovf_evt  = (inc != 2'd0);
                    state_nx = ACC_FULL;
                end
            end
        endcase
    end

endmodule

// File: rtl/err_irq.sv
module err_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic ovf_evt,
    input  logic tmr_clr,
    input  logic ovf_clr,
    input  logic tmr_mask,
    input  logic ovf_mask,
    output logic tmr_flag,
    output logic ovf_flag,
    output logic irq
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_flag <= 1'b0;
            ovf_flag <= 1'b0;
        end else begin
            if (tick)         tmr_flag <= 1'b1;
            else if (tmr_clr) tmr_flag <= 1'b0;
            if (ovf_evt)      ovf_flag <= 1'b1;
            else if (ovf_clr) ovf_flag <= 1'b0;
        end
    end

    assign irq = (tmr_flag & ~tmr_mask) | (ovf_flag & ~ovf_mask);

endmodule

// File: rtl/err_tally_top.sv
module err_tally_top
    import err_tally_pkg::*;
#(
    parameter int SEC_CYCLES = 100_000_000,
    parameter int CNT_W      = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_line_bpv,
    input  logic       ev_line_exz,
    input  logic       ev_sys_bpv,
    input  logic       ev_sys_exz,
    input  logic       ev_pattern,
    input  logic [2:0] src_sel,
    input  logic       auto_mode,
    input  logic       upd_req,
    input  logic       tx_nrz,
    input  logic       tmr_mask,
    input  logic       ovf_mask,
    input  logic       tmr_clr,
    input  logic       ovf_clr,
    output logic [7:0] held_hi,
    output logic [7:0] held_lo,
    output logic       tmr_flag,
    output logic       ovf_flag,
    output logic       irq
);

    localparam int HALF = CNT_W / 2;

    logic [1:0]       inc;
    logic             tick;
    logic             xfer;
    logic             ovf_evt;
    logic [CNT_W-1:0] run_cnt;
    logic [CNT_W-1:0] held;
    acc_state_e       acc_state;

    err_src_mux u_mux (
        .ev_line_bpv (ev_line_bpv),
        .ev_line_exz (ev_line_exz),
        .ev_sys_bpv  (ev_sys_bpv),
        .ev_sys_exz  (ev_sys_exz),
        .ev_pattern  (ev_pattern),
        .src_sel     (src_sel),
        .tx_nrz      (tx_nrz),
        .inc         (inc)
    );

    err_sec_timer #(.SEC_CYCLES(SEC_CYCLES)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    assign xfer = auto_mode ? tick : upd_req;

    err_accum #(.CNT_W(CNT_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (inc),
        .xfer    (xfer),
        .run_cnt (run_cnt),
        .held    (held),
        .ovf_evt (ovf_evt),
        .state   (acc_state)
    );

    err_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .ovf_evt  (ovf_evt),
        .tmr_clr  (tmr_clr),
        .ovf_clr  (ovf_clr),
        .tmr_mask (tmr_mask),
        .ovf_mask (ovf_mask),
        .tmr_flag (tmr_flag),
        .ovf_flag (ovf_flag),
        .irq      (irq)
    );

    assign held_hi = held[CNT_W-1:HALF];
    assign held_lo = held[HALF-1:0];

endmodule

// File: rtl/err_tally_chk.sv
module err_tally_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tick,
    input logic        xfer,
    input logic [1:0]  inc,
    input logic [15:0] run_cnt,
    input logic [15:0] held,
    input logic        tmr_flag,
    input logic        ovf_flag,
    input logic        tmr_mask,
    input logic        ovf_mask,
    input logic        irq,
    input logic [2:0]  src_sel,
    input logic        tx_nrz,
    input logic        auto_mode
);

    assert_nrz_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_nrz && (src_sel == 3'd3 || src_sel == 3'd5)) |-> (inc == 2'd0));

    assert_auto_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_mode && tick) |=> (run_cnt <= 16'd2));

    assert_tmr_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> tmr_flag);

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt == 16'hFFFF && !xfer) |=> (run_cnt == 16'hFFFF));

    assert_ovf_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt == 16'hFFFF && !xfer && inc != 2'd0) |=> ovf_flag);

    assert_irq_unmasked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((tmr_flag && !tmr_mask) || (ovf_flag && !ovf_mask)) |-> irq);

    assert_held_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer |=> $stable(held));

endmodule

bind err_tally_top err_tally_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .xfer      (xfer),
    .inc       (inc),
    .run_cnt   (run_cnt),
    .held      (held),
    .tmr_flag  (tmr_flag),
    .ovf_flag  (ovf_flag),
    .tmr_mask  (tmr_mask),
    .ovf_mask  (ovf_mask),
    .irq       (irq),
    .src_sel   (src_sel),
    .tx_nrz    (tx_nrz),
    .auto_mode (auto_mode)
);

// File: tb/tb_err_tally_top.sv
module tb_err_tally_top;

    localparam int T = 50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_line_bpv = 0, ev_line_exz = 0, ev_sys_bpv = 0, ev_sys_exz = 0, ev_pattern = 0;
    logic [2:0] src_sel = 3'd0;
    logic auto_mode = 0, upd_req = 0, tx_nrz = 0;
    logic tmr_mask = 0, ovf_mask = 0, tmr_clr = 0, ovf_clr = 0;
    logic [7:0] held_hi, held_lo;
    logic tmr_flag, ovf_flag, irq;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";

    int m_cnt = 0, m_held = 0, m_edge = 0;
    bit m_tf = 0, m_of = 0;

    always #5 clk = ~clk;

    err_tally_top #(.SEC_CYCLES(T), .CNT_W(16)) dut (
        .clk(clk), .rst_n(rst_n),
        .ev_line_bpv(ev_line_bpv), .ev_line_exz(ev_line_exz),
        .ev_sys_bpv(ev_sys_bpv), .ev_sys_exz(ev_sys_exz), .ev_pattern(ev_pattern),
        .src_sel(src_sel), .auto_mode(auto_mode), .upd_req(upd_req), .tx_nrz(tx_nrz),
        .tmr_mask(tmr_mask), .ovf_mask(ovf_mask), .tmr_clr(tmr_clr), .ovf_clr(ovf_clr),
        .held_hi(held_hi), .held_lo(held_lo),
        .tmr_flag(tmr_flag), .ovf_flag(ovf_flag), .irq(irq)
    );

    function automatic int model_inc();
        int b;
        b = 0;
        case (src_sel)
            3'd0: b = int'(ev_line_bpv);
            3'd1: b = int'(ev_line_exz);
            3'd2: b = int'(ev_line_bpv) + int'(ev_line_exz);
            3'd3: b = tx_nrz ? 0 : int'(ev_sys_bpv);
            3'd4: b = int'(ev_sys_exz);
            3'd5: b = tx_nrz ? 0 : int'(ev_sys_bpv) + int'(ev_sys_exz);
            3'd6: b = int'(ev_pattern);
            default: b = 0;
        endcase
        return b;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_held = 0; m_edge = 0; m_tf = 0; m_of = 0;
        end else begin
            int b;
            bit tk, xf, ov;
            b  = model_inc();
            tk = ((m_edge % T) == T - 1);
            xf = auto_mode ? tk : upd_req;
            ov = 0;
            if (xf) begin
                m_held = m_cnt;
                m_cnt  = b;
            end else if (m_cnt + b > 65535) begin
                m_cnt = 65535;
                ov    = 1;
            end else begin
                m_cnt = m_cnt + b;
            end
            if (tk) m_tf = 1; else if (tmr_clr) m_tf = 0;
            if (ov) m_of = 1; else if (ovf_clr) m_of = 0;
            m_edge++;
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s t=%0t actual=%0h expected=%0h", req, $time, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(cur_req, int'({held_hi, held_lo}), m_held);
        chk("R7", int'(tmr_flag), int'(m_tf));
        chk("R8", int'(ovf_flag), int'(m_of));
        chk("R9", int'(irq), int'((m_tf && !tmr_mask) || (m_of && !ovf_mask)));
    endtask

    task automatic rand_events(int density);
        ev_line_bpv = ($urandom % 100) < density;
        ev_line_exz = ($urandom % 100) < density;
        ev_sys_bpv  = ($urandom % 100) < density;
        ev_sys_exz  = ($urandom % 100) < density;
        ev_pattern  = ($urandom % 100) < density;
    endtask

    task automatic run(int n, int upd_pct, int clr_pct, bit rnd_mask);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare_all();
            rand_events(40);
            upd_req = ($urandom % 100) < upd_pct;
            tmr_clr = ($urandom % 100) < clr_pct;
            ovf_clr = ($urandom % 100) < clr_pct;
            if (rnd_mask) begin
                tmr_mask = $urandom % 2;
                ovf_mask = $urandom % 2;
            end
        end
    endtask

    initial begin
        #1_500_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R1";
        chk("R1", int'({held_hi, held_lo}), 0);
        chk("R1", int'(tmr_flag), 0);
        chk("R1", int'(irq), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", int'({held_hi, held_lo}), 0);
        chk("R1", int'(ovf_flag), 0);

        // R2: every select code, manual transfers expose the tally
        cur_req = "R2";
        for (int s = 0; s < 8; s++) begin
            src_sel = 3'(s);
            run(40, 10, 5, 0);
        end

        // R3: combined codes with dense double events
        cur_req = "R3";
        src_sel = 3'd2; run(60, 10, 5, 0);
        src_sel = 3'd5; run(60, 10, 5, 0);

        // R4: NRZ format suppresses system BPV choices only
        cur_req = "R4";
        tx_nrz = 1'b1;
        for (int s = 3; s < 6; s++) begin
            src_sel = 3'(s);
            run(60, 10, 5, 0);
        end
        tx_nrz = 1'b0;

        // R5: automatic transfer on each expiry, upd_req ignored (R6)
        cur_req = "R5";
        auto_mode = 1'b1;
        src_sel = 3'd6;
        run(300, 30, 5, 0);

        // R6: manual mode, timer does not transfer
        cur_req = "R6";
        auto_mode = 1'b0;
        src_sel = 3'd0;
        run(300, 3, 5, 0);

        // R7 / R9: flag clears and random masks
        cur_req = "R7";
        auto_mode = 1'b1;
        run(300, 0, 20, 1);
        cur_req = "R9";
        run(200, 0, 10, 1);
        tmr_mask = 0; ovf_mask = 0;

        // R10: held value kept until the next expiry, then overwritten
        cur_req = "R10";
        src_sel = 3'd1;
        run(250, 0, 5, 0);

        // R8: drive the count into saturation with double events
        cur_req = "R8";
        auto_mode = 1'b0;
        src_sel = 3'd2;
        @(negedge clk);
        upd_req = 1'b1; tmr_clr = 0; ovf_clr = 0;
        @(negedge clk);
        upd_req = 1'b0;
        ev_line_bpv = 1; ev_line_exz = 1;
        for (int i = 0; i < 33000; i++) begin
            @(negedge clk);
            if (i % 64 == 0) compare_all();
        end
        chk("R8", int'(ovf_flag), 1);
        upd_req = 1'b1;
        @(negedge clk);
        upd_req = 1'b0; ev_line_bpv = 0; ev_line_exz = 0;
        chk("R8", int'({held_hi, held_lo}), 16'hFFFF);
        compare_all();
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        chk("R8", int'(ovf_flag), 0);
        compare_all();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule